// File: doc/BRIEF.md
# Output Channel Fault Monitor

This block supervises a group of high-side output channels (four by default). Each channel has an on-state request, an overcurrent comparator input and an undercurrent comparator input. The block drives a gated output enable for each channel. An overcurrent shuts that channel down at once. The channel then comes back in one of two ways: after a programmable restart delay, or only after the host clears the channel's overcurrent bit.

An undercurrent reading counts as an underload only while the channel is actually driving, and only after it has held for a filter time. The block keeps sticky overcurrent and underload bits for every channel. It also produces two global flags. The global underload flag ignores any channel whose mask bit is set.

The host reads status through a plain register port. A read can leave the bits as they are or clear every bit it returned. The status ports are plain control and status pins with no handshake. A read is a single-cycle strobe that the block always accepts.

Top module: `chan_fault_mon`

## Requirements
- R1: When `oc_in[i]` is sampled high at a clock edge, channel i's overcurrent bit is set, `out_en[i]` reads 0 and `glb_oc` reads 1 after that same edge.
- R2: With `auto_rst` = 1, after the last edge that sampled `oc_in[i]` high, `out_en[i]` stays 0 for exactly D cycles and then follows `on_st[i]` again. D is chosen by `rst_dly_sel`: code 0 gives DLY0, code 1 gives DLY1, code 2 gives DLY2, code 3 gives DLY3.
- R3: A new overcurrent sample during a running restart delay starts the full delay again from that edge.
- R4: With `auto_rst` = 0, a shut-down channel keeps `out_en[i]` = 0 for as long as its overcurrent bit is set. After a clearing read removes the bit at edge E, `out_en[i]` follows `on_st[i]` from edge E+1 on.
- R5: The underload filter advances only in cycles where `out_en[i]` = 1. A cycle with `out_en[i]` = 0 resets the filter count to zero.
- R6: Channel i's underload bit is set at the edge that takes the ULD_T-th consecutive sample with `uc_in[i]` = 1 and `out_en[i]` = 1. A streak shorter than ULD_T sets nothing, and a gap restarts the count.
- R7: `glb_uld` is 1 exactly when some channel i has its underload bit set and `uld_mask[i]` = 0. `glb_oc` is 1 exactly when some overcurrent bit is set.
- R8: A cycle with `rd_en` = 1 loads the current status word into `rd_data` at the next edge. If `rd_clr` = 1 as well, every status bit is cleared at that same edge. With `rd_en` = 0, `rd_data` holds its value.
- R9: When a clearing read and a new fault land on the same edge, the fault wins and the bit stays set.
- R10: Status word layout: channel k has its overcurrent bit at position 13-2k and its underload bit at position 12-2k. Bits 15:14 and bits 5:0 read 0.
- R11: After reset, all status bits, both global flags, `rd_data` and all output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| on_st | input | N_CH | Per-channel on-state request |
| oc_in | input | N_CH | Per-channel overcurrent comparator |
| uc_in | input | N_CH | Per-channel undercurrent comparator |
| auto_rst | input | 1 | 1 = timed automatic restart, 0 = restart only after host clear |
| rst_dly_sel | input | 2 | Restart delay code (0..3) |
| uld_mask | input | N_CH | 1 = channel's underload is kept out of glb_uld |
| rd_en | input | 1 | Status read strobe |
| rd_clr | input | 1 | With rd_en: clear all status bits |
| rd_data | output | 16 | Status word captured by the last read |
| out_en | output | N_CH | Gated per-channel output enable |
| glb_oc | output | 1 | Any overcurrent bit set |
| glb_uld | output | 1 | Any unmasked underload bit set |

## Verification
Output enables and status bits are registered, so they change one clock after the stimulus edge. The global flags are combinational from those bits and follow in the same cycle. `rd_data` is valid one edge after the read strobe. A host clear releases a manual-mode channel one edge later still. The bench drives inputs and samples outputs on the falling edge. For the restart delay it counts the falling edges at which the enable is low, so every delay code must give exactly D. The underload checks sweep streak lengths across the filter boundary. The mask checks sweep all pairs of set pattern and mask.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int STAT_W   = 16;
  localparam int STAT_TOP = 13;  // overcurrent bit of channel 0
  localparam int MAX_CH   = 4;   // channels that fit between the pad bits

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cw_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cfm_oc_guard.sv
module cfm_oc_guard #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oc_hit,
  input  logic          on_st,
  input  logic          auto_rst,
  input  logic [TW-1:0] dly_m1,
  input  logic          clr,
  output logic          oc_flag,
  output logic          out_en
);
  logic          shut;
  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oc_flag <= 1'b0;
      shut    <= 1'b0;
      tmr     <= '0;
    end else begin
      oc_flag <= oc_hit | (oc_flag & ~clr);
      if (oc_hit) begin
        shut <= 1'b1;
        tmr  <= dly_m1;
      end else if (shut) begin
        if (auto_rst) begin
          if (tmr == '0) shut <= 1'b0;
          else           tmr  <= tmr - 1'b1;
        end else if (!oc_flag) begin
          shut <= 1'b0;
        end
      end
    end
  end

  assign out_en = on_st & ~shut;
endmodule

// File: rtl/cfm_uld_filter.sv
module cfm_uld_filter #(
  parameter int ULD_T = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic uc,
  input  logic clr,
  output logic uld_flag
);
  localparam int CW = cfm_pkg::cw_for(ULD_T);
  localparam logic [CW-1:0] LAST = CW'(ULD_T - 1);

  logic [CW-1:0] cnt;
  logic          hit;

  assign hit = active & uc & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      uld_flag <= 1'b0;
    end else begin
      if (active && uc) begin
        if (cnt != LAST) cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
      end
      uld_flag <= hit | (uld_flag & ~clr);
    end
  end
endmodule

// File: rtl/cfm_stat_pack.sv
module cfm_stat_pack #(
  parameter int N_CH = 4
) (
  input  logic [N_CH-1:0]            oc_v,
  input  logic [N_CH-1:0]            uld_v,
  output logic [cfm_pkg::STAT_W-1:0] word
);
  for (genvar k = 0; k < cfm_pkg::STAT_W; k++) begin : g_bit
    if (k <= cfm_pkg::STAT_TOP && k > cfm_pkg::STAT_TOP - 2 * N_CH) begin : g_used
      if (((cfm_pkg::STAT_TOP - k) % 2) == 0) begin : g_oc
        assign word[k] = oc_v[(cfm_pkg::STAT_TOP - k) / 2];
      end else begin : g_uld
        assign word[k] = uld_v[(cfm_pkg::STAT_TOP - k) / 2];
      end
    end else begin : g_pad
      assign word[k] = 1'b0;
    end
  end
endmodule

// File: rtl/chan_fault_mon.sv
module chan_fault_mon #(
  parameter int N_CH  = 4,
  parameter int ULD_T = 50,
  parameter int DLY0  = 100,
  parameter int DLY1  = 200,
  parameter int DLY2  = 400,
  parameter int DLY3  = 800
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_CH-1:0]             on_st,
  input  logic [N_CH-1:0]             oc_in,
  input  logic [N_CH-1:0]             uc_in,
  input  logic                        auto_rst,
  input  logic [1:0]                  rst_dly_sel,
  input  logic [N_CH-1:0]             uld_mask,
  input  logic                        rd_en,
  input  logic                        rd_clr,
  output logic [cfm_pkg::STAT_W-1:0]  rd_data,
  output logic [N_CH-1:0]             out_en,
  output logic                        glb_oc,
  output logic                        glb_uld
);
  import cfm_pkg::*;

  localparam int DMAX = imax(imax(DLY0, DLY1), imax(DLY2, DLY3));
  localparam int TW   = cw_for(DMAX);

  logic [TW-1:0]     dly_m1;
  logic              clr;
  logic [N_CH-1:0]   oc_sts;
  logic [N_CH-1:0]   uld_sts;
  logic [STAT_W-1:0] word;

  always_comb begin
    case (rst_dly_sel)
      2'd0:    dly_m1 = TW'(DLY0 - 1);
      2'd1:    dly_m1 = TW'(DLY1 - 1);
      2'd2:    dly_m1 = TW'(DLY2 - 1);
      default: dly_m1 = TW'(DLY3 - 1);
    endcase
  end

  assign clr = rd_en & rd_clr;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    cfm_oc_guard #(.TW(TW)) u_oc (
      .clk      (clk),
      .rst_n    (rst_n),
      .oc_hit   (oc_in[c]),
      .on_st    (on_st[c]),
      .auto_rst (auto_rst),
      .dly_m1   (dly_m1),
      .clr      (clr),
      .oc_flag  (oc_sts[c]),
      .out_en   (out_en[c])
    );
    cfm_uld_filter #(.ULD_T(ULD_T)) u_uld (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (out_en[c]),
      .uc       (uc_in[c]),
      .clr      (clr),
      .uld_flag (uld_sts[c])
    );
  end

  cfm_stat_pack #(.N_CH(N_CH)) u_pack (
    .oc_v  (oc_sts),
    .uld_v (uld_sts),
    .word  (word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= word;
  end

  assign glb_oc  = |oc_sts;
  assign glb_uld = |(uld_sts & ~uld_mask);
endmodule

// File: rtl/chan_fault_mon_chk.sv
module chan_fault_mon_chk #(
  parameter int N_CH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_CH-1:0]            on_st,
  input logic [N_CH-1:0]            oc_in,
  input logic [N_CH-1:0]            uc_in,
  input logic                       auto_rst,
  input logic [N_CH-1:0]            uld_mask,
  input logic                       rd_en,
  input logic                       rd_clr,
  input logic [cfm_pkg::STAT_W-1:0] rd_data,
  input logic [N_CH-1:0]            out_en,
  input logic                       glb_oc,
  input logic                       glb_uld,
  input logic [N_CH-1:0]            oc_sts,
  input logic [N_CH-1:0]            uld_sts
);
  initial begin
    a_r10_ch_fit: assert (N_CH >= 1 && N_CH <= cfm_pkg::MAX_CH);
  end

  a_r10_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:14] == 2'b00 && rd_data[5:0] == 6'b0);

  for (genvar i = 0; i < N_CH; i++) begin : g_a
    a_r1_oc_shut: assert property (@(posedge clk) disable iff (!rst_n)
      oc_in[i] |=> (!out_en[i] && oc_sts[i] && glb_oc));
    a_r4_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_rst && oc_sts[i] && on_st[i] && !out_en[i]) |=> !out_en[i]);
    a_r5_uld_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
      (!uc_in[i] || !out_en[i]) |=> !$rose(uld_sts[i]));
    a_r7_uld_global: assert property (@(posedge clk) disable iff (!rst_n)
      (uld_sts[i] && !uld_mask[i]) |-> glb_uld);
    a_r9_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_clr && oc_in[i]) |=> oc_sts[i]);
  end
endmodule

bind chan_fault_mon chan_fault_mon_chk #(.N_CH(N_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .on_st    (on_st),
  .oc_in    (oc_in),
  .uc_in    (uc_in),
  .auto_rst (auto_rst),
  .uld_mask (uld_mask),
  .rd_en    (rd_en),
  .rd_clr   (rd_clr),
  .rd_data  (rd_data),
  .out_en   (out_en),
  .glb_oc   (glb_oc),
  .glb_uld  (glb_uld),
  .oc_sts   (oc_sts),
  .uld_sts  (uld_sts)
);

// File: tb/tb_chan_fault_mon.sv
`timescale 1ns/1ps
module tb_chan_fault_mon;
  localparam int N  = 4;
  localparam int UT = 6;
  localparam int D0 = 3, D1 = 5, D2 = 8, D3 = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  on_st = '0, oc_in = '0, uc_in = '0, uld_mask = '0;
  logic          auto_rst = 1'b0, rd_en = 1'b0, rd_clr = 1'b0;
  logic [1:0]    rst_dly_sel = 2'd0;
  logic [15:0]   rd_data;
  logic [N-1:0]  out_en;
  logic          glb_oc, glb_uld;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chan_fault_mon #(.N_CH(N), .ULD_T(UT), .DLY0(D0), .DLY1(D1), .DLY2(D2), .DLY3(D3)) dut (
    .clk(clk), .rst_n(rst_n), .on_st(on_st), .oc_in(oc_in), .uc_in(uc_in),
    .auto_rst(auto_rst), .rst_dly_sel(rst_dly_sel), .uld_mask(uld_mask),
    .rd_en(rd_en), .rd_clr(rd_clr), .rd_data(rd_data), .out_en(out_en),
    .glb_oc(glb_oc), .glb_uld(glb_uld));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dly_of(input int code);
    case (code)
      0: return D0; 1: return D1; 2: return D2; default: return D3;
    endcase
  endfunction

  function automatic logic [15:0] pack(input logic [N-1:0] oc, input logic [N-1:0] ul);
    logic [15:0] w = '0;
    for (int k = 0; k < N; k++) begin
      w[13 - 2 * k] = oc[k];
      w[12 - 2 * k] = ul[k];
    end
    return w;
  endfunction

  task automatic rd(input logic c);
    rd_en = 1'b1; rd_clr = c;
    @(negedge clk);
    rd_en = 1'b0; rd_clr = 1'b0;
  endtask

  task automatic count_low(input int ch, inout int cnt);
    while (!out_en[ch] && cnt < 200) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 out_en", out_en, 0);
    check("R11 glb_oc", glb_oc, 0);
    check("R11 glb_uld", glb_uld, 0);
    check("R11 rd_data", rd_data, 0);
    rd(1'b0);
    check("R11 status word", rd_data, 0);
    on_st = '1;
    @(negedge clk);
    check("R11 enables follow on_st", out_en, 4'hF);

    // R1 R2 auto restart over every code and channel
    auto_rst = 1'b1;
    for (int code = 0; code < 4; code++) begin
      for (int ch = 0; ch < N; ch++) begin
        rst_dly_sel = 2'(code);
        oc_in[ch] = 1'b1;
        @(negedge clk);
        oc_in[ch] = 1'b0;
        check("R1 out_en off", out_en[ch], 0);
        check("R1 others on", out_en & ~(4'(1) << ch), 4'hF & ~(4'(1) << ch));
        check("R1 glb_oc", glb_oc, 1);
        cnt = 0;
        count_low(ch, cnt);
        check("R2 off cycles", cnt, dly_of(code));
        rd(1'b1);
        check("R10 oc word", rd_data, pack(4'(1) << ch, '0));
        check("R8 glb_oc after clear", glb_oc, 0);
      end
    end

    // R3 retrigger
    for (int ch = 0; ch < N; ch++) begin
      rst_dly_sel = 2'd1;
      oc_in[ch] = 1'b1; @(negedge clk);
      oc_in[ch] = 1'b0; @(negedge clk);
      oc_in[ch] = 1'b1; @(negedge clk);
      oc_in[ch] = 1'b0;
      cnt = 2;
      count_low(ch, cnt);
      check("R3 retrigger off cycles", cnt, D1 + 2);
      rd(1'b1);
    end

    // R4 manual restart
    auto_rst = 1'b0;
    for (int ch = 0; ch < N; ch++) begin
      oc_in[ch] = 1'b1; @(negedge clk);
      oc_in[ch] = 1'b0;
      repeat (3 * D3) @(negedge clk);
      check("R4 still off", out_en[ch], 0);
      rd(1'b0);
      check("R8 read no clear word", rd_data, pack(4'(1) << ch, '0));
      check("R4 off after plain read", out_en[ch], 0);
      rd(1'b1);
      check("R8 clear word", rd_data, pack(4'(1) << ch, '0));
      check("R4 off one edge after clear", out_en[ch], 0);
      @(negedge clk);
      check("R4 on after clear", out_en[ch], 1);
      check("R8 glb_oc cleared", glb_oc, 0);
    end

    // R9 collision
    oc_in[2] = 1'b1;
    @(negedge clk);
    rd(1'b1);
    rd(1'b0);
    check("R9 fault wins", rd_data, pack(4'b0100, '0));
    oc_in[2] = 1'b0;
    @(negedge clk);
    rd(1'b1);
    @(negedge clk);
    check("R9 released", out_en, 4'hF);
    rd(1'b0);
    check("R8 cleared", rd_data, 0);

    // R6 streak length sweep
    auto_rst = 1'b1;
    for (int ch = 0; ch < N; ch++) begin
      for (int L = 1; L <= UT + 2; L++) begin
        uc_in[ch] = 1'b1;
        repeat (L) @(negedge clk);
        uc_in[ch] = 1'b0;
        check("R6 glb_uld streak", glb_uld, (L >= UT) ? 1 : 0);
        rd(1'b1);
        check("R6 uld word", rd_data, pack('0, (L >= UT) ? (4'(1) << ch) : 4'(0)));
      end
    end

    // R6 gap restarts the count
    uc_in[1] = 1'b1; repeat (UT - 1) @(negedge clk);
    uc_in[1] = 1'b0; @(negedge clk);
    uc_in[1] = 1'b1; repeat (UT - 1) @(negedge clk);
    uc_in[1] = 1'b0;
    rd(1'b1);
    check("R6 gap no uld", rd_data, 0);

    // R5 off cycles: never counts, and an off cycle resets
    on_st[3] = 1'b0; uc_in[3] = 1'b1;
    repeat (2 * UT) @(negedge clk);
    on_st[3] = 1'b1; uc_in[3] = 1'b0;
    rd(1'b1);
    check("R5 no uld while off", rd_data, 0);
    uc_in[0] = 1'b1;
    repeat (UT - 1) @(negedge clk);
    on_st[0] = 1'b0; @(negedge clk);
    on_st[0] = 1'b1;
    repeat (UT - 1) @(negedge clk);
    uc_in[0] = 1'b0;
    rd(1'b1);
    check("R5 off cycle resets filter", rd_data, 0);

    // R7 R10 pattern by mask sweep
    for (int s = 0; s < 16; s++) begin
      uc_in = 4'(s);
      repeat (UT) @(negedge clk);
      uc_in = '0;
      for (int m = 0; m < 16; m++) begin
        uld_mask = 4'(m);
        #1;
        check("R7 glb_uld mask", glb_uld, ((s & ~m & 15) != 0) ? 1 : 0);
      end
      uld_mask = '0;
      rd(1'b1);
      check("R10 uld pattern word", rd_data, pack('0, 4'(s)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule